// File: doc/BRIEF.md
# Descriptor-Chained Audio DMA Channel

This block is one DMA channel of a peripheral bus. It moves 16-bit audio samples between system memory and a small on-chip sample FIFO, following a linked list of descriptors that software builds in memory. Each descriptor names a buffer, gives how many bytes to move from or into it, optionally asks for a completion interrupt, and points at the next descriptor. Software can close the list back on itself, so the channel runs round a ring of buffers until it is told to stop.

Software programs the address of the first descriptor, then writes one control word. That word starts or stops the channel, picks the direction (memory to device for playback, device to memory for capture), places the FIFO window inside the on-chip sample store and sets a high-water mark. The channel only moves data in bursts that begin once that mark is reached. A readable buffer pointer tells software where in memory the transfer currently stands. The device side of the FIFO is a plain pop port (playback) or push port (capture).

Top module: `audma_channel`

## Requirements
- R1: The channel reads a descriptor as three 32-bit words at the descriptor pointer plus 0, 4 and 8: the buffer address, the count word (byte count in bits 15:0, interrupt enable in bit 31) and the next descriptor address. Register 0 is the descriptor pointer, register 1 the control word, register 2 the buffer pointer (read only).
- R2: A control write with bit 0 set starts fetching at the descriptor pointer. A control write with bit 0 clear stops the channel: from the next cycle no memory request is made and control bit 0 reads 0. Every control write empties the FIFO.
- R3: With control bit 1 clear (transmit), halfwords are read from memory in ascending address order, two bytes per halfword, and leave the device pop port in that order. The channel follows the next pointers, and a chain that points back to an earlier descriptor repeats without end.
- R4: With control bit 1 set (receive), halfwords pushed at the device port are written to consecutive ascending memory addresses of the current buffer, and the memory port never writes in transmit mode.
- R5: After the last halfword of a descriptor with bit 31 set has moved, control bit 3 and the irq output read 1 and stay 1 until the next control write clears them. A descriptor with bit 31 clear never sets them.
- R6: A descriptor with a byte count of zero moves no data; the channel goes straight on to its next descriptor.
- R7: The FIFO holds (end - begin) * 4 halfwords, where end is control bits 31:24 and begin is control bits 23:16, both in 8-byte units; its level never exceeds that.
- R8: Control bits 15:8 give the high-water mark in halfwords. In transmit a burst of memory reads begins only once the free space reaches the mark and runs until the FIFO is full; in receive memory writes begin only once the level reaches the mark and run until the FIFO is empty.
- R9: The buffer pointer register reads the memory address of the next halfword to be moved in the current buffer.
- R10: After reset all three registers read 0, the irq output is 0, no memory request is made and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 descriptor pointer, 1 control, 2 buffer pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_req | output | 1 | Memory access this cycle, completed in the same cycle |
| mem_we | output | 1 | Memory access is a halfword write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 16 | Halfword to write |
| mem_rdata | input | 32 | Read data: 32-bit word for descriptors, bits 15:0 for samples |
| dev_rd | input | 1 | Device pops the FIFO head (transmit) |
| dev_rdata | output | 16 | FIFO head halfword |
| dev_wr | input | 1 | Device pushes a halfword (receive) |
| dev_wdata | input | 16 | Halfword pushed by the device |
| dev_level | output | 6 | Number of halfwords held in the FIFO |
| irq | output | 1 | Completion interrupt status |

## Verification
The assertions assume that memory answers every request in the same cycle and that software changes the FIFO window only through a control write, which also empties the FIFO; the stimulus only ever reshapes the window through such writes. They also assume the device pops only when the level is nonzero and pushes only in receive mode, and the bench drives the device port that way, one halfword per cycle at most. Memory is modelled as an array of halfwords whose descriptor words are laid out before each start, so the expected sample order, pointer values and interrupt state follow from the chains alone.

// File: rtl/audma_pkg.sv
package audma_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned BCNT_W = 16;
  localparam int unsigned IE_BIT = 31;

  localparam logic [1:0] RA_DPTR = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_BPTR = 2'd2;

  typedef struct packed {
    logic [7:0] win_end;
    logic [7:0] win_beg;
    logic [7:0] hwm;
    logic [3:0] rsvd;
    logic       irq;
    logic       load;
    logic       rx;
    logic       act;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FBUF = 3'd1,
    ST_FCNT = 3'd2,
    ST_FNXT = 3'd3,
    ST_XFER = 3'd4
  } eng_st_e;

endpackage

// File: rtl/audma_fifo.sv
module audma_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [7:0]    beg_dw,
  input  logic [7:0]    end_dw,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic [LW-1:0] cap,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_off, wr_off_n, rd_off, rd_off_n;
  logic [LW-1:0] level_n;
  logic [9:0]    base_hw, span_hw;
  logic [PW-1:0] wr_phys, rd_phys;
  logic          do_push, do_pop;

  always_comb begin
    base_hw = {beg_dw, 2'b00};
    span_hw = (end_dw > beg_dw) ? ({end_dw, 2'b00} - base_hw) : 10'd0;
    cap     = (span_hw > 10'(DEPTH)) ? LW'(DEPTH) : span_hw[LW-1:0];
  end

  assign full    = (level >= cap);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wr_phys = PW'(base_hw + 10'(wr_off));
  assign rd_phys = PW'(base_hw + 10'(rd_off));
  assign head    = store[rd_phys];

  always_comb begin
    wr_off_n = wr_off;
    rd_off_n = rd_off;
    level_n  = level;
    if (flush) begin
      wr_off_n = '0;
      rd_off_n = '0;
      level_n  = '0;
    end else begin
      if (do_push) begin
        wr_off_n = (({1'b0, wr_off} + 1'b1) == cap) ? '0 : wr_off + 1'b1;
      end
      if (do_pop) begin
        rd_off_n = (({1'b0, rd_off} + 1'b1) == cap) ? '0 : rd_off + 1'b1;
      end
      level_n = level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off <= '0;
      rd_off <= '0;
      level  <= '0;
    end else begin
      wr_off <= wr_off_n;
      rd_off <= rd_off_n;
      level  <= level_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) begin
      store[wr_phys] <= push_data;
    end
  end

endmodule

// File: rtl/audma_engine.sv
module audma_engine
  import audma_pkg::*;
#(
  parameter int unsigned LW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              rx,
  input  logic              dptr_we,
  input  logic [WORD_W-1:0] dptr_wdata,
  input  logic [7:0]        hwm,
  input  logic [LW-1:0]     cap,
  input  logic [LW-1:0]     level,
  input  logic              full,
  input  logic              empty,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              irq_set,
  output logic [WORD_W-1:0] bptr,
  output logic [WORD_W-1:0] dptr,
  output logic              active,
  output logic              beat
);

  localparam int unsigned REM_W = BCNT_W - 1;

  eng_st_e           st, st_n;
  logic [WORD_W-1:0] dptr_n, bptr_n, nxt, nxt_n;
  logic [REM_W-1:0]  rem, rem_n;
  logic              ie, ie_n;
  logic              burst, burst_n;
  logic [LW-1:0]     free_hw;
  logic              may_move;

  assign free_hw  = cap - level;
  assign may_move = rx ? !empty : !full;
  assign active   = (st != ST_IDLE);

  always_comb begin
    if (burst) begin
      burst_n = may_move;
    end else if (rx) begin
      burst_n = !empty && (16'(level) >= 16'(hwm));
    end else begin
      burst_n = !full && (16'(free_hw) >= 16'(hwm));
    end
    if (start || !active) begin
      burst_n = 1'b0;
    end
  end

  always_comb begin
    st_n      = st;
    dptr_n    = dptr;
    bptr_n    = bptr;
    nxt_n     = nxt;
    rem_n     = rem;
    ie_n      = ie;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dptr;
    fifo_push = 1'b0;
    fifo_pop  = 1'b0;
    irq_set   = 1'b0;
    beat      = 1'b0;
    case (st)
      ST_FBUF: begin
        mem_req = 1'b1;
        bptr_n  = mem_rdata;
        st_n    = ST_FCNT;
      end
      ST_FCNT: begin
        mem_req  = 1'b1;
        mem_addr = dptr + 32'd4;
        rem_n    = mem_rdata[BCNT_W-1:1];
        ie_n     = mem_rdata[IE_BIT];
        st_n     = ST_FNXT;
      end
      ST_FNXT: begin
        mem_req  = 1'b1;
        mem_addr = dptr + 32'd8;
        nxt_n    = mem_rdata;
        if (rem == '0) begin
          irq_set = ie;
          dptr_n  = mem_rdata;
          st_n    = ST_FBUF;
        end else begin
          st_n = ST_XFER;
        end
      end
      ST_XFER: begin
        if (burst && may_move) begin
          beat      = 1'b1;
          mem_req   = 1'b1;
          mem_we    = rx;
          mem_addr  = bptr;
          fifo_push = !rx;
          fifo_pop  = rx;
          bptr_n    = bptr + 32'd2;
          rem_n     = rem - 1'b1;
          if (rem == REM_W'(1)) begin
            irq_set = ie;
            dptr_n  = nxt;
            st_n    = ST_FBUF;
          end
        end
      end
      default: begin
        st_n = st;
      end
    endcase
    if (dptr_we) begin
      dptr_n = dptr_wdata;
    end
    if (start) begin
      st_n = ST_FBUF;
    end else if (stop) begin
      st_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      dptr  <= '0;
      bptr  <= '0;
      nxt   <= '0;
      rem   <= '0;
      ie    <= 1'b0;
      burst <= 1'b0;
    end else begin
      st    <= st_n;
      dptr  <= dptr_n;
      bptr  <= bptr_n;
      nxt   <= nxt_n;
      rem   <= rem_n;
      ie    <= ie_n;
      burst <= burst_n;
    end
  end

endmodule

// File: rtl/audma_channel.sv
module audma_channel
  import audma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  localparam int unsigned LW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [HALF_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              dev_rd,
  output logic [HALF_W-1:0] dev_rdata,
  input  logic              dev_wr,
  input  logic [HALF_W-1:0] dev_wdata,
  output logic [LW-1:0]     dev_level,
  output logic              irq
);

  ctrl_t             ctrl_q, ctrl_n, ctrl_wv;
  logic              irq_q, irq_n;
  logic              ctrl_wr, start, stop, dptr_we;
  logic              eng_push, eng_pop, eng_irq_set, eng_active, eng_beat;
  logic [WORD_W-1:0] eng_bptr, eng_dptr;
  logic [LW-1:0]     fifo_cap;
  logic              fifo_full, fifo_empty;
  logic              f_push, f_pop;
  logic [HALF_W-1:0] f_data, f_head;
  logic              rx_mode;

  assign ctrl_wv = ctrl_t'(reg_wdata);
  assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
  assign dptr_we = reg_we && (reg_addr == RA_DPTR);
  assign start   = ctrl_wr && ctrl_wv.act;
  assign stop    = ctrl_wr && !ctrl_wv.act;
  assign rx_mode = ctrl_q.rx;

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_wr) begin
      ctrl_n      = ctrl_wv;
      ctrl_n.rsvd = '0;
      ctrl_n.irq  = 1'b0;
      ctrl_n.act  = 1'b0;
    end
    irq_n = ctrl_wr ? 1'b0 : (irq_q || eng_irq_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_DPTR: reg_rdata = eng_dptr;
      RA_CTRL: reg_rdata = {ctrl_q.win_end, ctrl_q.win_beg, ctrl_q.hwm, 4'b0000,
                            irq_q, ctrl_q.load, ctrl_q.rx, eng_active};
      RA_BPTR: reg_rdata = eng_bptr;
      default: reg_rdata = '0;
    endcase
  end

  assign f_push    = rx_mode ? dev_wr : eng_push;
  assign f_pop     = rx_mode ? eng_pop : dev_rd;
  assign f_data    = rx_mode ? dev_wdata : mem_rdata[HALF_W-1:0];
  assign mem_wdata = f_head;
  assign dev_rdata = f_head;
  assign irq       = irq_q;

  audma_fifo #(
    .DEPTH (FIFO_DEPTH),
    .DW    (HALF_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (ctrl_wr),
    .beg_dw    (ctrl_q.win_beg),
    .end_dw    (ctrl_q.win_end),
    .push      (f_push),
    .push_data (f_data),
    .pop       (f_pop),
    .head      (f_head),
    .level     (dev_level),
    .cap       (fifo_cap),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  audma_engine #(
    .LW (LW)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .rx         (rx_mode),
    .dptr_we    (dptr_we),
    .dptr_wdata (reg_wdata),
    .hwm        (ctrl_q.hwm),
    .cap        (fifo_cap),
    .level      (dev_level),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .fifo_push  (eng_push),
    .fifo_pop   (eng_pop),
    .irq_set    (eng_irq_set),
    .bptr       (eng_bptr),
    .dptr       (eng_dptr),
    .active     (eng_active),
    .beat       (eng_beat)
  );

endmodule

// File: rtl/audma_channel_chk.sv
module audma_channel_chk #(
  parameter int unsigned LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic          irq,
  input logic [LW-1:0] dev_level,
  input logic [LW-1:0] fifo_cap,
  input logic          rx_mode,
  input logic          eng_active,
  input logic          eng_beat,
  input logic [31:0]   eng_bptr
);

  logic ctl_w;
  assign ctl_w = reg_we && (reg_addr == 2'd1);

  assert_stop_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !reg_wdata[0]) |=> !mem_req);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_active) |-> $past(ctl_w && reg_wdata[0]));

  assert_no_tx_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> rx_mode);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_w) |=> irq);

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w |=> !irq);

  assert_level_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_level <= fifo_cap);

  assert_bptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_beat |=> (eng_bptr == $past(eng_bptr) + 32'd2));

endmodule

bind audma_channel audma_channel_chk #(.LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .irq        (irq),
  .dev_level  (dev_level),
  .fifo_cap   (fifo_cap),
  .rx_mode    (rx_mode),
  .eng_active (eng_active),
  .eng_beat   (eng_beat),
  .eng_bptr   (eng_bptr)
);

// File: tb/tb_audma_channel.sv
module tb_audma_channel;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        dev_rd;
  logic [15:0] dev_rdata;
  logic        dev_wr;
  logic [15:0] dev_wdata;
  logic [5:0]  dev_level;
  logic        irq;

  logic [15:0] mem16 [0:1023];
  logic [9:0]  midx;
  int          wcount;
  int          nchk;
  int          nfail;

  audma_channel dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .dev_rd    (dev_rd),
    .dev_rdata (dev_rdata),
    .dev_wr    (dev_wr),
    .dev_wdata (dev_wdata),
    .dev_level (dev_level),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign midx      = mem_addr[10:1];
  assign mem_rdata = {mem16[midx + 10'd1], mem16[midx]};

  initial wcount = 0;
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      mem16[midx] <= mem_wdata;
      wcount      <= wcount + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    mem16[a/2]     = w[15:0];
    mem16[a/2 + 1] = w[31:16];
  endtask

  task automatic put_desc(input int a, input logic [31:0] b, input logic [31:0] c,
                          input logic [31:0] n);
    put_word(a, b);
    put_word(a + 4, c);
    put_word(a + 8, n);
  endtask

  task automatic wait_level(input int lvl);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (dev_level == 6'(lvl)) break;
    end
  endtask

  task automatic pop_expect(input string tag, input logic [15:0] exp);
    @(negedge clk);
    check(tag, {16'h0, dev_rdata}, {16'h0, exp});
    dev_rd = 1'b1;
    @(negedge clk);
    dev_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd_reg(2'd0, v); check("R10 dptr after reset", v, 32'h0);
    rd_reg(2'd1, v); check("R10 ctrl after reset", v, 32'h0);
    rd_reg(2'd2, v); check("R10 bptr after reset", v, 32'h0);
    check("R10 irq/mem_req/level", {24'h0, irq, mem_req, dev_level}, 32'h0);
  endtask

  task automatic t_tx_ring();
    logic [31:0] v;
    logic [15:0] exp_seq [10];
    for (int i = 0; i < 4; i++) mem16[(32'h200 >> 1) + i] = 16'hA000 + 16'(i);
    for (int i = 0; i < 3; i++) mem16[(32'h280 >> 1) + i] = 16'hB000 + 16'(i);
    mem16[32'h300 >> 1] = 16'hDEAD;
    put_desc(32'h100, 32'h200, 32'h8000_0008, 32'h10C);
    put_desc(32'h10C, 32'h300, 32'h8000_0000, 32'h118);
    put_desc(32'h118, 32'h280, 32'h0000_0006, 32'h100);
    exp_seq = '{16'hA000, 16'hA001, 16'hA002, 16'hA003, 16'hB000,
                16'hB001, 16'hB002, 16'hA000, 16'hA001, 16'hA002};
    wr_reg(2'd0, 32'h100);
    rd_reg(2'd0, v); check("R1 dptr readback", v, 32'h100);
    wr_reg(2'd1, 32'h0200_0401);
    wait_level(8);
    repeat (10) @(negedge clk);
    check("R7 tx level capped at 8", {26'h0, dev_level}, 32'd8);
    rd_reg(2'd1, v); check("R5 irq set after flagged descriptor", {31'h0, v[3]}, 32'd1);
    for (int i = 0; i < 3; i++) pop_expect("R3 tx order", exp_seq[i]);
    repeat (10) @(negedge clk);
    check("R8 no refill below high-water", {26'h0, dev_level}, 32'd5);
    for (int i = 3; i < 10; i++) pop_expect("R3 R6 tx ring order, zero count skipped", exp_seq[i]);
    check("R5 irq held", {31'h0, irq}, 32'd1);
    wr_reg(2'd1, 32'h0000_0004);
    rd_reg(2'd1, v); check("R2 R5 ctrl after stop", v, 32'h0000_0004);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2 no request after stop", {31'h0, mem_req}, 32'd0);
    end
    check("R2 fifo emptied by ctrl write", {26'h0, dev_level}, 32'd0);
  endtask

  task automatic t_window_noirq();
    logic [31:0] v;
    put_desc(32'h160, 32'h280, 32'h0000_0006, 32'h160);
    wr_reg(2'd0, 32'h160);
    wr_reg(2'd1, 32'h0302_0201);
    wait_level(4);
    repeat (10) @(negedge clk);
    check("R7 window begin 2 end 3 holds 4", {26'h0, dev_level}, 32'd4);
    rd_reg(2'd2, v); check("R9 bptr at stall", v, 32'h282);
    pop_expect("R7 window data", 16'hB000);
    pop_expect("R7 window data", 16'hB001);
    pop_expect("R7 window data", 16'hB002);
    pop_expect("R3 self ring wrap", 16'hB000);
    repeat (10) @(negedge clk);
    check("R5 no irq without enable", {31'h0, irq}, 32'd0);
    wr_reg(2'd1, 32'h0000_0000);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    int w0;
    put_desc(32'h1A0, 32'h380, 32'h8000_0008, 32'h1A0);
    for (int i = 0; i < 4; i++) mem16[(32'h380 >> 1) + i] = 16'h0;
    wr_reg(2'd0, 32'h1A0);
    wr_reg(2'd1, 32'h0400_0403);
    repeat (8) @(negedge clk);
    w0 = wcount;
    for (int i = 0; i < 3; i++) begin
      dev_wr    = 1'b1;
      dev_wdata = 16'hC000 + 16'(i);
      @(negedge clk);
    end
    dev_wr = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 rx no write below high-water", 32'(wcount - w0), 32'd0);
    check("R8 rx level", {26'h0, dev_level}, 32'd3);
    rd_reg(2'd2, v); check("R9 rx bptr before burst", v, 32'h380);
    dev_wr    = 1'b1;
    dev_wdata = 16'hC003;
    @(negedge clk);
    dev_wr = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 rx write count", 32'(wcount - w0), 32'd4);
    for (int i = 0; i < 4; i++)
      check("R4 rx memory data", {16'h0, mem16[(32'h380 >> 1) + i]}, 32'hC000 + 32'(i));
    check("R5 rx irq", {31'h0, irq}, 32'd1);
    rd_reg(2'd2, v); check("R1 R9 ring refetch bptr", v, 32'h380);
    wr_reg(2'd1, 32'h0000_0000);
    rd_reg(2'd1, v); check("R2 R5 rx stop clears", v, 32'h0);
  endtask

  initial begin
    nchk = 0;
    nfail = 0;
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem16[i] = 16'h0;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = 2'd0;
    reg_wdata = 32'h0;
    dev_rd    = 1'b0;
    dev_wr    = 1'b0;
    dev_wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_ring();
    t_window_noirq();
    t_rx();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule